// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with HI/LO Result Pair

This block multiplies or divides two integer operands one bit per clock cycle. It keeps its results in a dedicated pair of holding registers, HI and LO, which sit apart from any general register file. A multiply leaves the upper half of the double-width product in HI and the lower half in LO. A divide leaves the quotient in LO and the remainder in HI. Neither operation names a destination. Software reaches the results only through explicit move-from commands, and it can preload either register through move-to commands.

Each command is a single-cycle `start` pulse with an operation code on `op`, plus `sgn`, which selects two's-complement or zero-extended interpretation of the operands. While an arithmetic operation runs, `busy` is high. During that time a move-from request is held and answered as soon as the result is written. A move-to request or a second arithmetic start arriving during that time is discarded.

The control is a four-state machine:
- `ST_IDLE` goes to `ST_MUL` on a multiply start, or to `ST_DIV` on a divide start.
- `ST_MUL` and `ST_DIV` each run one step per cycle for WIDTH cycles, then go to `ST_FIX`.
- `ST_FIX` applies the sign correction, writes HI and LO, and returns to `ST_IDLE`.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, `busy` and `res_valid` are low, and reading HI and LO returns zero.
- R2: Operation codes on `op` are 0 multiply, 1 divide, 2 move-from-HI, 3 move-from-LO, 4 move-to-HI, 5 move-to-LO; codes 6 and 7 do nothing. With `sgn`=1, a multiply treats both operands as two's complement and leaves product bits [2W-1:W] in HI and bits [W-1:0] in LO.
- R3: With `sgn`=0, a multiply treats both operands as unsigned.
- R4: With `sgn`=1, a divide leaves the quotient, truncated toward zero, in LO and the remainder in HI. The remainder carries the sign of the dividend. Both are kept to W bits.
- R5: With `sgn`=0, a divide treats both operands as unsigned.
- R6: `busy` rises in the cycle after an accepted multiply or divide start and stays high for exactly WIDTH+1 cycles.
- R7: With `busy` low, move-to-HI or move-to-LO loads that register from `opa`. A move-from presents the register on `result`, with `res_valid` high, in the next cycle.
- R8: A move-to issued while `busy` is high leaves HI and LO unchanged and does not change `busy`.
- R9: A move-from issued while `busy` is high gets its answer in the first cycle `busy` is low: `res_valid` high and `result` holding the new value. `res_valid` is never high while `busy` is high.
- R10: A multiply or divide start issued while `busy` is high is ignored. The running operation keeps its length and its result.
- R11: A divide by zero raises nothing and takes the normal WIDTH+1 busy cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command strobe, one cycle per command |
| op | input | 3 | Operation code (see R2) |
| sgn | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| opa | input | WIDTH | Multiplicand, dividend, or move-to data |
| opb | input | WIDTH | Multiplier or divisor |
| busy | output | 1 | Multiply or divide in progress |
| res_valid | output | 1 | `result` carries a move-from answer this cycle |
| result | output | WIDTH | Move-from read-out |

## Verification
The bench builds the unit with WIDTH=4. At that width every operand pair of both operations can be swept in both signed and unsigned mode, and the expected values come from integer arithmetic in the bench. The sweep therefore covers the most negative operand, division of the most negative value by -1 (where the quotient wraps), and every sign combination for quotient and remainder. At this width the WIDTH+1 busy window is short, so the hold-off, discard and timing cases each run as directed sequences.

// File: rtl/muldiv_pkg.sv
`timescale 1ns/1ps
package muldiv_pkg;
    typedef enum logic [2:0] {
        OP_MUL  = 3'd0,
        OP_DIV  = 3'd1,
        OP_MFHI = 3'd2,
        OP_MFLO = 3'd3,
        OP_MTHI = 3'd4,
        OP_MTLO = 3'd5,
        OP_NOP6 = 3'd6,
        OP_NOP7 = 3'd7
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_DIV  = 2'd2,
        ST_FIX  = 2'd3
    } md_state_e;
endpackage

// File: rtl/md_fsm.sv
`timescale 1ns/1ps
module md_fsm
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [2:0] op,
    output logic       busy,
    output logic       accept,
    output logic       step_mul,
    output logic       step_div,
    output logic       finish
);
    localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

    md_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start && op == OP_MUL)      state_d = ST_MUL;
                else if (start && op == OP_DIV) state_d = ST_DIV;
            end
            ST_MUL, ST_DIV: begin
                if (cnt_q == '0) state_d = ST_FIX;
            end
            ST_FIX: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 cnt_q <= '0;
        else if (accept)                            cnt_q <= LAST_STEP;
        else if ((step_mul || step_div) && cnt_q != '0) cnt_q <= cnt_q - CW'(1);
    end

    // outputs
    always_comb begin
        busy     = 1'b0;
        accept   = 1'b0;
        step_mul = 1'b0;
        step_div = 1'b0;
        finish   = 1'b0;
        unique case (state_q)
            ST_IDLE: accept = start && (op == OP_MUL || op == OP_DIV);
            ST_MUL: begin
                busy     = 1'b1;
                step_mul = 1'b1;
            end
            ST_DIV: begin
                busy     = 1'b1;
                step_div = 1'b1;
            end
            ST_FIX: begin
                busy   = 1'b1;
                finish = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/md_mul_step.sv
`timescale 1ns/1ps
module md_mul_step #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] acc_hi,
    input  logic [WIDTH-1:0] acc_lo,
    input  logic [WIDTH-1:0] mcand,
    output logic [WIDTH-1:0] nxt_hi,
    output logic [WIDTH-1:0] nxt_lo
);
    logic [WIDTH:0] sum;

    // add the multiplicand when the current multiplier bit is set, then shift right
    always_comb begin
        if (acc_lo[0]) sum = {1'b0, acc_hi} + {1'b0, mcand};
        else           sum = {1'b0, acc_hi};
        nxt_hi = sum[WIDTH:1];
        nxt_lo = {sum[0], acc_lo[WIDTH-1:1]};
    end
endmodule

// File: rtl/md_div_step.sv
`timescale 1ns/1ps
module md_div_step #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] rem,
    input  logic [WIDTH-1:0] quo,
    input  logic [WIDTH-1:0] dvsr,
    output logic [WIDTH-1:0] nxt_rem,
    output logic [WIDTH-1:0] nxt_quo
);
    logic [WIDTH:0]   shifted;
    logic [WIDTH-1:0] trial;

    // restoring step: bring in the next dividend bit, subtract if it fits
    always_comb begin
        shifted = {rem, quo[WIDTH-1]};
        trial   = shifted[WIDTH-1:0] - dvsr;
        if (shifted >= {1'b0, dvsr}) begin
            nxt_rem = trial;
            nxt_quo = {quo[WIDTH-2:0], 1'b1};
        end else begin
            nxt_rem = shifted[WIDTH-1:0];
            nxt_quo = {quo[WIDTH-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/muldiv_hilo.sv
`timescale 1ns/1ps
module muldiv_hilo
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic             sgn,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic             busy,
    output logic             res_valid,
    output logic [WIDTH-1:0] result
);
    localparam int DW = 2 * WIDTH;

    logic accept, step_mul, step_div, fin;

    // HI/LO double as the working accumulator while an operation runs
    logic [WIDTH-1:0] hi_q, lo_q, opnd_q, result_q;
    logic             neg_q, rneg_q, div_q, pend_q, pend_hi_q, rvalid_q;

    logic             neg_a, neg_b;
    logic [WIDTH-1:0] mag_a, mag_b;
    logic [WIDTH-1:0] mul_hi, mul_lo, div_rem, div_quo;
    logic [WIDTH-1:0] fix_hi, fix_lo;
    logic [DW-1:0]    prod_fix;
    logic             mf_req, sel_hi;

    md_fsm #(.WIDTH(WIDTH)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op       (op),
        .busy     (busy),
        .accept   (accept),
        .step_mul (step_mul),
        .step_div (step_div),
        .finish   (fin)
    );

    md_mul_step #(.WIDTH(WIDTH)) u_mul (
        .acc_hi (hi_q),
        .acc_lo (lo_q),
        .mcand  (opnd_q),
        .nxt_hi (mul_hi),
        .nxt_lo (mul_lo)
    );

    md_div_step #(.WIDTH(WIDTH)) u_div (
        .rem     (hi_q),
        .quo     (lo_q),
        .dvsr    (opnd_q),
        .nxt_rem (div_rem),
        .nxt_quo (div_quo)
    );

    // operand magnitudes
    always_comb begin
        neg_a = sgn & opa[WIDTH-1];
        neg_b = sgn & opb[WIDTH-1];
        mag_a = neg_a ? ({WIDTH{1'b0}} - opa) : opa;
        mag_b = neg_b ? ({WIDTH{1'b0}} - opb) : opb;
    end

    // sign correction applied in the fix-up state
    always_comb begin
        prod_fix = neg_q ? ({DW{1'b0}} - {hi_q, lo_q}) : {hi_q, lo_q};
        if (div_q) begin
            fix_lo = neg_q  ? ({WIDTH{1'b0}} - lo_q) : lo_q;
            fix_hi = rneg_q ? ({WIDTH{1'b0}} - hi_q) : hi_q;
        end else begin
            fix_hi = prod_fix[DW-1:WIDTH];
            fix_lo = prod_fix[WIDTH-1:0];
        end
    end

    always_comb begin
        mf_req = start && (op == OP_MFHI || op == OP_MFLO);
        sel_hi = mf_req ? (op == OP_MFHI) : pend_hi_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q      <= '0;
            lo_q      <= '0;
            opnd_q    <= '0;
            neg_q     <= 1'b0;
            rneg_q    <= 1'b0;
            div_q     <= 1'b0;
            pend_q    <= 1'b0;
            pend_hi_q <= 1'b0;
            result_q  <= '0;
            rvalid_q  <= 1'b0;
        end else begin
            rvalid_q <= 1'b0;

            // HI/LO and working state
            if (accept) begin
                opnd_q <= mag_b;
                hi_q   <= '0;
                lo_q   <= mag_a;
                neg_q  <= neg_a ^ neg_b;
                rneg_q <= neg_a;
                div_q  <= (op == OP_DIV);
            end else if (step_mul) begin
                hi_q <= mul_hi;
                lo_q <= mul_lo;
            end else if (step_div) begin
                hi_q <= div_rem;
                lo_q <= div_quo;
            end else if (fin) begin
                hi_q <= fix_hi;
                lo_q <= fix_lo;
            end else if (!busy && start) begin
                if (op == OP_MTHI) hi_q <= opa;
                if (op == OP_MTLO) lo_q <= opa;
            end

            // move-from read-out, held off while busy
            if (fin) begin
                if (pend_q || mf_req) begin
                    result_q <= sel_hi ? fix_hi : fix_lo;
                    rvalid_q <= 1'b1;
                end
                pend_q <= 1'b0;
            end else if (mf_req && busy) begin
                pend_q    <= 1'b1;
                pend_hi_q <= (op == OP_MFHI);
            end else if (mf_req) begin
                result_q <= (op == OP_MFHI) ? hi_q : lo_q;
                rvalid_q <= 1'b1;
            end
        end
    end

    assign res_valid = rvalid_q;
    assign result    = result_q;
endmodule

// File: rtl/muldiv_hilo_chk.sv
`timescale 1ns/1ps
module muldiv_hilo_chk #(
    parameter int WIDTH = 32
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [2:0] op,
    input logic       busy,
    input logic       res_valid,
    input logic       finish
);
    logic [15:0] bcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    bcnt <= '0;
        else if (busy) bcnt <= bcnt + 16'd1;
        else           bcnt <= '0;
    end

    p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (op == 3'd0 || op == 3'd1)) |=> busy);

    p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(busy)) |-> (bcnt == 16'(WIDTH + 1)));

    p_mf_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (op == 3'd2 || op == 3'd3)) |=> res_valid);

    p_mt_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish && start && (op == 3'd4 || op == 3'd5)) |=> busy);

    p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !busy);

    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish && start && (op == 3'd0 || op == 3'd1)) |=> busy);
endmodule

bind muldiv_hilo muldiv_hilo_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op        (op),
    .busy      (busy),
    .res_valid (res_valid),
    .finish    (fin)
);

// File: tb/muldiv_hilo_test.sv
`timescale 1ns/1ps
module muldiv_hilo_test;
    localparam int W = 4;
    localparam int M = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [2:0]   op = 3'd0;
    logic         sgn = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic         busy, res_valid;
    logic [W-1:0] result;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    muldiv_hilo #(.WIDTH(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op        (op),
        .sgn       (sgn),
        .opa       (opa),
        .opb       (opb),
        .busy      (busy),
        .res_valid (res_valid),
        .result    (result)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sx(input int v, input bit s);
        return (s && v >= M / 2) ? v - M : v;
    endfunction

    // issue one command, count busy cycles that follow
    task automatic run_op(input logic [2:0] o, input bit s, input int a, input int b,
                          output int nbusy);
        @(negedge clk);
        op = o; sgn = s; opa = W'(a); opb = W'(b); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        nbusy = 0;
        while (busy) begin
            nbusy++;
            @(negedge clk);
        end
    endtask

    // issue an arithmetic op, then inject a second command one cycle later
    task automatic run_inject(input logic [2:0] o, input int a, input int b,
                              input logic [2:0] io, input int ia, input int ib,
                              output int nbusy);
        @(negedge clk);
        op = o; sgn = 1'b0; opa = W'(a); opb = W'(b); start = 1'b1;
        @(negedge clk);
        nbusy = busy ? 1 : 0;
        op = io; opa = W'(ia); opb = W'(ib); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) begin
            nbusy++;
            @(negedge clk);
        end
    endtask

    task automatic read_reg(input logic [2:0] o, output int val, output int vld);
        @(negedge clk);
        op = o; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        val = int'(result);
        vld = int'(res_valid);
    endtask

    task automatic write_reg(input logic [2:0] o, input int v);
        @(negedge clk);
        op = o; opa = W'(v); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        #1_500_000;
        checks++;
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v, vld, nb, p, q, r, sa, sb, seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 res_valid", int'(res_valid), 0);
        read_reg(3'd2, v, vld);
        chk("R1 HI", v, 0);
        read_reg(3'd3, v, vld);
        chk("R1 LO", v, 0);

        // R7 move-to / move-from while idle
        write_reg(3'd4, 9);
        write_reg(3'd5, 6);
        read_reg(3'd2, v, vld);
        chk("R7 HI value", v, 9);
        chk("R7 valid", vld, 1);
        read_reg(3'd3, v, vld);
        chk("R7 LO value", v, 6);
        @(negedge clk);
        chk("R7 valid pulse ends", int'(res_valid), 0);

        // R2/R3/R4/R5/R6 exhaustive sweep
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < M; a++) begin
                for (int b = 0; b < M; b++) begin
                    sa = sx(a, s[0]);
                    sb = sx(b, s[0]);
                    p = sa * sb;
                    run_op(3'd0, s[0], a, b, nb);
                    chk("R6 mul busy length", nb, W + 1);
                    read_reg(3'd2, v, vld);
                    chk(s ? "R2 mul HI" : "R3 mul HI", v, (p >>> W) & (M - 1));
                    read_reg(3'd3, v, vld);
                    chk(s ? "R2 mul LO" : "R3 mul LO", v, p & (M - 1));
                    if (b != 0) begin
                        q = sa / sb;
                        r = sa % sb;
                        run_op(3'd1, s[0], a, b, nb);
                        chk("R6 div busy length", nb, W + 1);
                        read_reg(3'd3, v, vld);
                        chk(s ? "R4 quotient" : "R5 quotient", v, q & (M - 1));
                        read_reg(3'd2, v, vld);
                        chk(s ? "R4 remainder" : "R5 remainder", v, r & (M - 1));
                    end
                end
            end
        end

        // R11 divide by zero timing
        run_op(3'd1, 1'b0, 7, 0, nb);
        chk("R11 div by zero busy length", nb, W + 1);
        run_op(3'd1, 1'b1, 9, 0, nb);
        chk("R11 signed div by zero busy length", nb, W + 1);

        // R8 move-to during busy ignored (3*5 = 15: HI 0, LO 15)
        run_inject(3'd0, 3, 5, 3'd4, 9, 0, nb);
        chk("R8 busy length", nb, W + 1);
        read_reg(3'd2, v, vld);
        chk("R8 HI untouched", v, 0);
        run_inject(3'd0, 3, 5, 3'd5, 2, 0, nb);
        chk("R8 busy length LO", nb, W + 1);
        read_reg(3'd3, v, vld);
        chk("R8 LO untouched", v, 15);

        // R10 restart during busy ignored
        run_inject(3'd0, 3, 5, 3'd1, 13, 4, nb);
        chk("R10 busy length", nb, W + 1);
        read_reg(3'd3, v, vld);
        chk("R10 LO keeps product", v, 15);
        read_reg(3'd2, v, vld);
        chk("R10 HI keeps product", v, 0);

        // R9 move-from during busy: 13/4 unsigned -> LO 3
        @(negedge clk);
        op = 3'd1; sgn = 1'b0; opa = 4'd13; opb = 4'd4; start = 1'b1;
        @(negedge clk);
        op = 3'd3; start = 1'b1;
        seen = 0;
        @(negedge clk);
        start = 1'b0;
        while (busy) begin
            if (res_valid) seen++;
            @(negedge clk);
        end
        chk("R9 no valid while busy", seen, 0);
        chk("R9 valid at completion", int'(res_valid), 1);
        chk("R9 quotient delivered", int'(result), 3);

        // R9 held move-from of HI -> remainder 1
        @(negedge clk);
        op = 3'd1; opa = 4'd13; opb = 4'd4; start = 1'b1;
        @(negedge clk);
        op = 3'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        chk("R9 remainder delivered", int'(result), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule